// File: doc/BRIEF.md
# Board Interrupt Aggregator with Identification Words

This block sits in a board-level programmable logic device. It gathers up to sixteen external interrupt request lines into one 16-bit status word. Each line is first passed through a two-flop synchroniser. A status bit latches high when its source is seen high, and it stays high until software clears it. A per-bit mask, in which a 1 disables the bit, decides which latched bits can pull the single active-low, level-type interrupt line to the host low.

Software clears status bits in two writes to a separate clear register. The first write puts ones at the positions to clear, and the second write puts back zero. While a clear bit is held at 1, the matching status bit is forced to 0, even if its source is active. Three fixed identification words and a code-version word let the host check that the device is present before it touches anything else. The register bus is a plain synchronous 16-bit bus. Writes are captured on the clock edge, and read data is a combinational function of the current address and the register state.

Top module: `brd_irq_agg`

## Requirements
- R1: After reset, the mask register (offset 0x38) reads 0xFFFF, the status (0x10) and clear (0x20) registers read 0x0000, and irq_n is 1.
- R2: Offset 0x40 reads 0xAAAA, offset 0x48 reads 0x5555, offset 0x58 reads 0xCAFE, and offset 0x50 reads the VERSION parameter (default 0x0102).
- R3: A source line held high for at least one clock sets status bit n, where bit n belongs to source n. The bit is readable at offset 0x10 no later than three rising edges after the source rises. It then stays set after the source falls, until it is cleared.
- R4: irq_n is 0 exactly when some status bit is 1 and the mask bit at the same position is 0. A mask bit of 1 keeps its status bit from affecting irq_n, but the status bit still latches.
- R5: A write to offset 0x20 stores the write data. From the next clock on, every status bit whose clear bit is 1 reads 0, even while its source stays high. After 0x0000 is written back, a source that is still high sets its bit again.
- R6: The mask (0x38) and clear (0x20) registers read back the last value written to them.
- R7: Writes to the status, identification and version offsets, and to unmapped offsets, change no register. Reads of unmapped offsets return 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| src_in | input | 16 | Raw interrupt source lines, active high, asynchronous |
| irq_n | output | 1 | Active-low, level-type interrupt to the host |

## Verification
The assertions assume that bus_addr, bus_we and bus_wdata are stable around the rising edge, and that reset is held for several clocks, so that every $past term sees values that have already been reset. The source lines may change at any time, because the synchroniser absorbs them. The bench changes every input on the falling edge and holds each source pulse for two clocks, so no event is lost.

// File: rtl/brd_irq_pkg.sv
// Package: register offsets and fixed identification values shared by the
// interrupt aggregator modules. Assumes an 8-bit byte-offset register space.
package brd_irq_pkg;
    localparam int unsigned OFF_W = 8;
    localparam int unsigned ID_W  = 16;

    localparam logic [OFF_W-1:0] OFF_STATUS = 8'h10;
    localparam logic [OFF_W-1:0] OFF_CLEAR  = 8'h20;
    localparam logic [OFF_W-1:0] OFF_MASK   = 8'h38;
    localparam logic [OFF_W-1:0] OFF_ID_A   = 8'h40;
    localparam logic [OFF_W-1:0] OFF_ID_B   = 8'h48;
    localparam logic [OFF_W-1:0] OFF_VER    = 8'h50;
    localparam logic [OFF_W-1:0] OFF_ID_C   = 8'h58;

    localparam logic [ID_W-1:0] ID_A_VAL = 16'hAAAA;
    localparam logic [ID_W-1:0] ID_B_VAL = 16'h5555;
    localparam logic [ID_W-1:0] ID_C_VAL = 16'hCAFE;
endpackage

// File: rtl/brd_irq_sync.sv
// Two-flop synchroniser for a vector of independent asynchronous lines.
// Assumes each line is an unrelated level. No bus coherency is implied.
module brd_irq_sync #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    // Two-stage capture of the raw lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_async;
            sync_q <= meta_q;
        end
    end

    assign q_sync = sync_q;
endmodule

// File: rtl/brd_irq_status.sv
// Sticky status bits: one latch per source, set by the synchronised event
// and forced low while its clear bit is held. Clear wins over set.
module brd_irq_status #(
    parameter int unsigned NSRC = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt,
    input  logic [NSRC-1:0] clr,
    output logic [NSRC-1:0] status
);
    logic [NSRC-1:0] status_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        // Per-bit latch: the clear has priority, otherwise accumulate the event.
        always_ff @(posedge clk) begin
            if (!rst_n)      status_q[i] <= 1'b0;
            else if (clr[i]) status_q[i] <= 1'b0;
            else if (evt[i]) status_q[i] <= 1'b1;
        end
    end

    assign status = status_q;

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(clr)) == '0));                       // R5
    AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr == '0) |=> ((status_q & $past(evt)) == $past(evt)));        // R3
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (clr == '0) |=> ((status_q & $past(status_q)) == $past(status_q))); // R3
endmodule

// File: rtl/brd_irq_regs.sv
// Register file and read multiplexer: the writable mask and clear registers,
// the fixed identification words, and the version word. Assumes that write
// strobes are synchronous to clk. Unmapped reads return zero.
module brd_irq_regs
    import brd_irq_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned REG_W   = 16,
    parameter int unsigned NSRC    = 16,
    parameter logic [15:0] VERSION = 16'h0102
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [REG_W-1:0]  wdata,
    input  logic [NSRC-1:0]   status,
    output logic [REG_W-1:0]  rdata,
    output logic [REG_W-1:0]  mask_q,
    output logic [REG_W-1:0]  clr_q
);
    localparam logic [REG_W-1:0] MASK_RST = '1;

    logic hit_mask;
    logic hit_clr;
    logic [REG_W-1:0] status_w;

    assign hit_mask = (addr == ADDR_W'(OFF_MASK));
    assign hit_clr  = (addr == ADDR_W'(OFF_CLEAR));
    assign status_w = REG_W'(status);

    // Capture writes to the two writable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= MASK_RST;
            clr_q  <= '0;
        end else if (we) begin
            if (hit_mask) mask_q <= wdata;
            if (hit_clr)  clr_q  <= wdata;
        end
    end

    // Select read data by offset.
    always_comb begin
        rdata = '0;
        if      (addr == ADDR_W'(OFF_STATUS)) rdata = status_w;
        else if (hit_clr)                     rdata = clr_q;
        else if (hit_mask)                    rdata = mask_q;
        else if (addr == ADDR_W'(OFF_ID_A))   rdata = REG_W'(ID_A_VAL);
        else if (addr == ADDR_W'(OFF_ID_B))   rdata = REG_W'(ID_B_VAL);
        else if (addr == ADDR_W'(OFF_VER))    rdata = REG_W'(VERSION);
        else if (addr == ADDR_W'(OFF_ID_C))   rdata = REG_W'(ID_C_VAL);
    end

    AST_MASK_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && hit_mask) |=> $stable(mask_q));                          // R7
    AST_CLR_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && hit_clr) |=> $stable(clr_q));                            // R7
endmodule

// File: rtl/brd_irq_agg.sv
// Top of the board interrupt aggregator. It synchronises the sources,
// latches them into status, and drives the active-low interrupt from the
// unmasked status. Assumes 1 <= NSRC <= REG_W.
module brd_irq_agg #(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned REG_W   = 16,
    parameter int unsigned NSRC    = 16,
    parameter logic [15:0] VERSION = 16'h0102
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [NSRC-1:0]   src_in,
    output logic              irq_n
);
    logic [NSRC-1:0]  src_sync;
    logic [NSRC-1:0]  status;
    logic [REG_W-1:0] mask_q;
    logic [REG_W-1:0] clr_q;
    logic [NSRC-1:0]  pending;

    brd_irq_sync #(.WIDTH(NSRC)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(src_in), .q_sync(src_sync)
    );

    brd_irq_status #(.NSRC(NSRC)) u_status (
        .clk(clk), .rst_n(rst_n), .evt(src_sync),
        .clr(clr_q[NSRC-1:0]), .status(status)
    );

    brd_irq_regs #(
        .ADDR_W(ADDR_W), .REG_W(REG_W), .NSRC(NSRC), .VERSION(VERSION)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we),
        .wdata(bus_wdata), .status(status), .rdata(bus_rdata),
        .mask_q(mask_q), .clr_q(clr_q)
    );

    // Level interrupt: low while any unmasked status bit is set.
    always_comb begin
        pending = status & ~mask_q[NSRC-1:0];
        irq_n   = ~(|pending);
    end

    AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !(bus_we && (bus_addr == ADDR_W'(8'h38) || bus_addr == ADDR_W'(8'h20)))
         && clr_q == '0) |=> !irq_n);                                    // R4
    AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (status != '0));                                      // R4
endmodule

// File: tb/tb_brd_irq_agg.sv
module tb_brd_irq_agg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic [15:0] src_in = 16'h0;
    logic        irq_n;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_status = 16'h0;
    logic [15:0] exp_mask = 16'hFFFF;

    brd_irq_agg dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
        .irq_n(irq_n)
    );

    always #4 clk = ~clk;

    function automatic logic exp_irq_n(input logic [15:0] st, input logic [15:0] mk);
        return ~(|(st & ~mk));
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(input logic [15:0] p);
        @(negedge clk);
        src_in = p;
        idle(2);
        src_in = 16'h0;
    endtask

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd1234));
        idle(4);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(8'h38, v); check("R1 mask", v, 16'hFFFF);
        rd(8'h10, v); check("R1 status", v, 16'h0000);
        rd(8'h20, v); check("R1 clear", v, 16'h0000);
        check("R1 irq_n", {15'h0, irq_n}, 16'h1);
        // R2 identification
        rd(8'h40, v); check("R2 id a", v, 16'hAAAA);
        rd(8'h48, v); check("R2 id b", v, 16'h5555);
        rd(8'h58, v); check("R2 id c", v, 16'hCAFE);
        rd(8'h50, v); check("R2 version", v, 16'h0102);
        // R7 unmapped reads and ignored writes
        rd(8'h14, v); check("R7 unmapped read", v, 16'h0000);
        wr(8'h40, 16'h1234); wr(8'h10, 16'hFFFF); wr(8'h3C, 16'h0000);
        rd(8'h40, v); check("R7 id a after write", v, 16'hAAAA);
        rd(8'h38, v); check("R7 mask after stray writes", v, 16'hFFFF);
        rd(8'h10, v); check("R7 status after write", v, 16'h0000);
        rd(8'h20, v); check("R7 clear after stray writes", v, 16'h0000);
        // R3 latch timing: status visible three edges after source rises
        @(negedge clk); src_in = 16'h0001;
        idle(2); rd(8'h10, v); check("R3 not yet", v, 16'h0000);
        @(negedge clk); rd(8'h10, v); check("R3 latched", v, 16'h0001);
        src_in = 16'h0; idle(4);
        rd(8'h10, v); check("R3 sticky", v, 16'h0001);
        exp_status = 16'h0001;
        // R4 masked: irq stays high, then unmask
        check("R4 masked irq", {15'h0, irq_n}, 16'h1);
        wr(8'h38, 16'hFFFE); exp_mask = 16'hFFFE;
        #1; check("R4 unmasked irq", {15'h0, irq_n}, 16'h0);
        rd(8'h38, v); check("R6 mask readback", v, 16'hFFFE);
        // R5 clear priority while source held high
        @(negedge clk); src_in = 16'h0008; idle(4);
        exp_status |= 16'h0008;
        rd(8'h10, v); check("R3 bit3", v, exp_status);
        wr(8'h20, 16'h0009);
        rd(8'h20, v); check("R6 clear readback", v, 16'h0009);
        idle(3); rd(8'h10, v); check("R5 held clear", v, 16'h0000);
        check("R5 irq released", {15'h0, irq_n}, 16'h1);
        wr(8'h20, 16'h0000); idle(1);
        rd(8'h10, v); check("R5 re-arm", v, 16'h0008);
        src_in = 16'h0;
        wr(8'h20, 16'hFFFF); wr(8'h20, 16'h0000); idle(1);
        rd(8'h10, v); check("R5 clear all", v, 16'h0000);
        exp_status = 16'h0;
        // Random mix: R3, R4, R5
        for (int it = 0; it < 60; it++) begin
            logic [15:0] p;
            p = 16'($urandom);
            if (it % 3 == 0) begin
                exp_mask = 16'($urandom);
                wr(8'h38, exp_mask);
            end
            pulse(p & 16'($urandom));
            idle(3);
            exp_status = 16'h0;
            rd(8'h10, v);
            exp_status = v;
            if (it % 4 == 0) begin
                logic [15:0] c;
                c = 16'($urandom);
                wr(8'h20, c); wr(8'h20, 16'h0000); idle(1);
                exp_status &= ~c;
                rd(8'h10, v); check("R5 random clear", v, exp_status);
            end
            check("R4 random irq", {15'h0, irq_n}, {15'h0, exp_irq_n(exp_status, exp_mask)});
            wr(8'h20, 16'hFFFF); wr(8'h20, 16'h0000); idle(1);
            rd(8'h10, v); check("R5 random clear all", v, 16'h0000);
        end
        // R3 random single-bit latch with expected set value
        for (int b = 0; b < 16; b++) begin
            pulse(16'h1 << b); idle(3);
            rd(8'h10, v); check("R3 single bit", v, 16'h1 << b);
            wr(8'h20, 16'h1 << b); wr(8'h20, 16'h0); idle(1);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule